// File: doc/BRIEF.md
# Three-Dimensional DMA Address Generator

This block walks a strided three-level transfer and turns it into a stream of array requests. Each request carries a source address, a destination address and a byte count. The transfer is a number of frames. Each frame is a number of arrays, and each array is a run of contiguous bytes. Source and destination each have their own signed 16-bit stride between arrays and their own signed 16-bit stride between frames. A configuration is loaded while the block is idle. Each trigger then releases a burst of work: one array when the block runs array-at-a-time, or every array of one frame when it runs frame-at-a-time.

The two modes measure the frame stride from different points. In array-at-a-time mode the stride is added to the start of the last array of the frame, and the per-frame array count is refilled from a reload value. In frame-at-a-time mode the stride is added to the start of the frame just moved. After each trigger the updated addresses and counts are presented on write-back outputs, together with a pulse that says whether work remains or the transfer has ended. A trigger that arrives while any count is zero moves nothing and flags an error instead.

Top module: `dma3d_addr_gen`

## Requirements
- R1: After reset there is no request, no completion or error pulse, busy is low, and the written-back array and frame counts are zero.
- R2: A load pulse while idle captures the whole configuration, and the write-back outputs then show the loaded start addresses and counts. A load pulse while busy is ignored.
- R3: With cfg_ab_mode = 0, each trigger issues exactly one array request with req_bytes equal to the array size. The next array of the same frame starts at the previous start plus the sign-extended array stride.
- R4: With cfg_ab_mode = 0, after the last array of a frame the next start is the last array's start plus the frame stride, and the array count is refilled from the reload value.
- R5: With cfg_ab_mode = 1, one trigger issues all arrays of a frame, array k at frame start plus k times the array stride. The next frame starts at the frame start plus the frame stride.
- R6: Source and destination addresses advance by their own separate array and frame strides.
- R7: One cycle after the last request of a trigger is accepted, done_mid pulses if work remains, and the write-back outputs show the updated addresses and counts. At most one of done_mid, done_final and err is high in any cycle.
- R8: The trigger that ends the last frame pulses done_final instead of done_mid, and the written-back array and frame counts are zero.
- R9: A trigger while the array size, array count or frame count is zero pulses err in the next cycle, issues no request and raises no completion.
- R10: A trigger while busy is ignored: the transfer in progress issues exactly its own arrays and advances the counts once.
- R11: While req_valid is high and req_ready is low, the request stays valid with unchanged addresses.
- R12: Address arithmetic is modulo 2^32 on sign-extended strides, so addresses wrap through zero in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture configuration (idle only) |
| cfg_ab_mode | input | 1 | 0: one array per trigger, 1: one frame per trigger |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_acnt | input | 16 | Bytes per array |
| cfg_bcnt | input | 16 | Arrays per frame |
| cfg_bcnt_rld | input | 16 | Array count refill value at frame boundaries |
| cfg_ccnt | input | 16 | Frames in the transfer |
| cfg_src_bidx | input | 16 | Signed source array stride |
| cfg_dst_bidx | input | 16 | Signed destination array stride |
| cfg_src_cidx | input | 16 | Signed source frame stride |
| cfg_dst_cidx | input | 16 | Signed destination frame stride |
| trig | input | 1 | Trigger pulse |
| req_valid | output | 1 | Array request valid |
| req_ready | input | 1 | Array request accepted |
| req_src | output | 32 | Array source address |
| req_dst | output | 32 | Array destination address |
| req_bytes | output | 16 | Array byte count |
| busy | output | 1 | Trigger in progress |
| done_mid | output | 1 | Intermediate completion pulse |
| done_final | output | 1 | Final completion pulse |
| err | output | 1 | Trigger with a zero count |
| wb_src | output | 32 | Current source address |
| wb_dst | output | 32 | Current destination address |
| wb_bcnt | output | 16 | Current array count |
| wb_ccnt | output | 16 | Current frame count |

## Verification
The bench targets the frame boundary in each mode. A design that takes the frame stride from the wrong base would land each new frame a whole frame too far, or one array short, in the twelve-byte contiguous cases. A design that skips the array-count refill would stall after the first frame with an error. Other cases cover long back-pressure, where a request that moved while stalled would show up as a changed address. They also cover triggers and loads injected mid-burst, which would duplicate arrays or corrupt the walk, and strides that carry through the top or bottom of the address space, which would expose missing sign extension. Randomised configurations run every transfer until the following trigger reports an error, so a final pulse that comes early or late, or nonzero counts left behind, would be caught.

// File: rtl/dma3d_pkg.sv
`timescale 1ns/1ps
package dma3d_pkg;
  localparam int ADDR_W_DEF = 32;
  localparam int CNT_W_DEF  = 16;
  localparam int IDX_W_DEF  = 16;

  typedef enum logic {
    SQ_IDLE  = 1'b0,
    SQ_ISSUE = 1'b1
  } seq_state_t;
endpackage

// File: rtl/dma3d_ctx.sv
`timescale 1ns/1ps
module dma3d_ctx #(
  parameter int AW = dma3d_pkg::ADDR_W_DEF,
  parameter int CW = dma3d_pkg::CNT_W_DEF,
  parameter int IW = dma3d_pkg::IDX_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          cfg_ab_mode,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_acnt,
  input  logic [CW-1:0] cfg_bcnt,
  input  logic [CW-1:0] cfg_bcnt_rld,
  input  logic [CW-1:0] cfg_ccnt,
  input  logic [IW-1:0] cfg_src_bidx,
  input  logic [IW-1:0] cfg_dst_bidx,
  input  logic [IW-1:0] cfg_src_cidx,
  input  logic [IW-1:0] cfg_dst_cidx,
  input  logic          step,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [CW-1:0] acnt,
  output logic [CW-1:0] bcnt,
  output logic [CW-1:0] ccnt,
  output logic [IW-1:0] src_bidx,
  output logic [IW-1:0] dst_bidx,
  output logic          ab_mode,
  output logic          any_zero,
  output logic          is_last
);
  localparam int EXT = AW - IW;
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;

  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] a_q, b_q, rld_q, c_q;
  logic [IW-1:0] sb_q, db_q, sc_q, dc_q;
  logic          ab_q;

  logic [AW-1:0] sb_ext, db_ext, sc_ext, dc_ext;
  logic          frame_end;

  assign sb_ext = {{EXT{sb_q[IW-1]}}, sb_q};
  assign db_ext = {{EXT{db_q[IW-1]}}, db_q};
  assign sc_ext = {{EXT{sc_q[IW-1]}}, sc_q};
  assign dc_ext = {{EXT{dc_q[IW-1]}}, dc_q};

  // a frame closes on every step in frame mode, on the last array otherwise
  assign frame_end = ab_q || (b_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0; dst_q <= '0;
      a_q <= '0; b_q <= '0; rld_q <= '0; c_q <= '0;
      sb_q <= '0; db_q <= '0; sc_q <= '0; dc_q <= '0;
      ab_q <= 1'b0;
    end else if (load) begin
      src_q <= cfg_src;       dst_q <= cfg_dst;
      a_q   <= cfg_acnt;      b_q   <= cfg_bcnt;
      rld_q <= cfg_bcnt_rld;  c_q   <= cfg_ccnt;
      sb_q  <= cfg_src_bidx;  db_q  <= cfg_dst_bidx;
      sc_q  <= cfg_src_cidx;  dc_q  <= cfg_dst_cidx;
      ab_q  <= cfg_ab_mode;
    end else if (step) begin
      if (!frame_end) begin
        src_q <= src_q + sb_ext;
        dst_q <= dst_q + db_ext;
        b_q   <= b_q - ONE;
      end else begin
        // base is the last array (array mode) or the frame start (frame mode),
        // both of which are src_q/dst_q at this point
        src_q <= src_q + sc_ext;
        dst_q <= dst_q + dc_ext;
        if (c_q == ONE) begin
          b_q <= ZERO;
          c_q <= ZERO;
        end else begin
          c_q <= c_q - ONE;
          if (!ab_q) b_q <= rld_q;
        end
      end
    end
  end

  assign cur_src  = src_q;
  assign cur_dst  = dst_q;
  assign acnt     = a_q;
  assign bcnt     = b_q;
  assign ccnt     = c_q;
  assign src_bidx = sb_q;
  assign dst_bidx = db_q;
  assign ab_mode  = ab_q;
  assign any_zero = (a_q == ZERO) || (b_q == ZERO) || (c_q == ZERO);
  assign is_last  = frame_end && (c_q == ONE);

  AST_CCNT_NO_RISE: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> (c_q <= $past(c_q))); // R4

  AST_STEP_NONZERO: assert property (@(posedge clk) disable iff (rst)
    step |-> !any_zero); // R9
endmodule

// File: rtl/dma3d_seq.sv
`timescale 1ns/1ps
module dma3d_seq
  import dma3d_pkg::*;
#(
  parameter int AW = dma3d_pkg::ADDR_W_DEF,
  parameter int CW = dma3d_pkg::CNT_W_DEF,
  parameter int IW = dma3d_pkg::IDX_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          trig,
  input  logic          ab_mode,
  input  logic          any_zero,
  input  logic          is_last,
  input  logic [CW-1:0] bcnt,
  input  logic [AW-1:0] base_src,
  input  logic [AW-1:0] base_dst,
  input  logic [IW-1:0] src_bidx,
  input  logic [IW-1:0] dst_bidx,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_src,
  output logic [AW-1:0] req_dst,
  output logic          step,
  output logic          busy,
  output logic          done_mid,
  output logic          done_final,
  output logic          err
);
  localparam int EXT = AW - IW;
  localparam logic [CW-1:0] ONE = CW'(1);

  seq_state_t    st_q;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] left_q;
  logic          vld_q, mid_q, fin_q, err_q;
  logic          hs;

  assign hs   = vld_q && req_ready;
  assign step = hs && (left_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      left_q <= '0;
      vld_q  <= 1'b0;
      mid_q  <= 1'b0;
      fin_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mid_q <= 1'b0;
      fin_q <= 1'b0;
      err_q <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (trig) begin
            if (any_zero) begin
              err_q <= 1'b1;
            end else begin
              st_q   <= SQ_ISSUE;
              vld_q  <= 1'b1;
              src_q  <= base_src;
              dst_q  <= base_dst;
              left_q <= ab_mode ? bcnt : ONE;
            end
          end
        end
        SQ_ISSUE: begin
          if (hs) begin
            if (left_q == ONE) begin
              st_q  <= SQ_IDLE;
              vld_q <= 1'b0;
              fin_q <= is_last;
              mid_q <= !is_last;
            end else begin
              left_q <= left_q - ONE;
              src_q  <= src_q + {{EXT{src_bidx[IW-1]}}, src_bidx};
              dst_q  <= dst_q + {{EXT{dst_bidx[IW-1]}}, dst_bidx};
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign req_valid  = vld_q;
  assign req_src    = src_q;
  assign req_dst    = dst_q;
  assign busy       = (st_q == SQ_ISSUE);
  assign done_mid   = mid_q;
  assign done_final = fin_q;
  assign err        = err_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_src) && $stable(req_dst))); // R11

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_mid, done_final, err})); // R7

  AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    err |-> !req_valid); // R9
endmodule

// File: rtl/dma3d_addr_gen.sv
`timescale 1ns/1ps
module dma3d_addr_gen #(
  parameter int AW = dma3d_pkg::ADDR_W_DEF,
  parameter int CW = dma3d_pkg::CNT_W_DEF,
  parameter int IW = dma3d_pkg::IDX_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_load,
  input  logic          cfg_ab_mode,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_acnt,
  input  logic [CW-1:0] cfg_bcnt,
  input  logic [CW-1:0] cfg_bcnt_rld,
  input  logic [CW-1:0] cfg_ccnt,
  input  logic [IW-1:0] cfg_src_bidx,
  input  logic [IW-1:0] cfg_dst_bidx,
  input  logic [IW-1:0] cfg_src_cidx,
  input  logic [IW-1:0] cfg_dst_cidx,
  input  logic          trig,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_src,
  output logic [AW-1:0] req_dst,
  output logic [CW-1:0] req_bytes,
  output logic          busy,
  output logic          done_mid,
  output logic          done_final,
  output logic          err,
  output logic [AW-1:0] wb_src,
  output logic [AW-1:0] wb_dst,
  output logic [CW-1:0] wb_bcnt,
  output logic [CW-1:0] wb_ccnt
);
  logic          load_ok, step, busy_w;
  logic [AW-1:0] cur_src, cur_dst;
  logic [CW-1:0] acnt, bcnt, ccnt;
  logic [IW-1:0] src_bidx, dst_bidx;
  logic          ab_mode, any_zero, is_last;

  assign load_ok = cfg_load && !busy_w;

  dma3d_ctx #(.AW(AW), .CW(CW), .IW(IW)) u_ctx (
    .clk(clk), .rst(rst), .load(load_ok),
    .cfg_ab_mode(cfg_ab_mode), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_acnt(cfg_acnt), .cfg_bcnt(cfg_bcnt), .cfg_bcnt_rld(cfg_bcnt_rld),
    .cfg_ccnt(cfg_ccnt), .cfg_src_bidx(cfg_src_bidx), .cfg_dst_bidx(cfg_dst_bidx),
    .cfg_src_cidx(cfg_src_cidx), .cfg_dst_cidx(cfg_dst_cidx),
    .step(step),
    .cur_src(cur_src), .cur_dst(cur_dst), .acnt(acnt), .bcnt(bcnt), .ccnt(ccnt),
    .src_bidx(src_bidx), .dst_bidx(dst_bidx), .ab_mode(ab_mode),
    .any_zero(any_zero), .is_last(is_last)
  );

  dma3d_seq #(.AW(AW), .CW(CW), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .trig(trig), .ab_mode(ab_mode),
    .any_zero(any_zero), .is_last(is_last), .bcnt(bcnt),
    .base_src(cur_src), .base_dst(cur_dst),
    .src_bidx(src_bidx), .dst_bidx(dst_bidx),
    .req_ready(req_ready), .req_valid(req_valid),
    .req_src(req_src), .req_dst(req_dst), .step(step), .busy(busy_w),
    .done_mid(done_mid), .done_final(done_final), .err(err)
  );

  assign busy      = busy_w;
  assign req_bytes = acnt;
  assign wb_src    = cur_src;
  assign wb_dst    = cur_dst;
  assign wb_bcnt   = bcnt;
  assign wb_ccnt   = ccnt;

  AST_FINAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    done_final |-> (wb_bcnt == '0 && wb_ccnt == '0)); // R8

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid); // R10
endmodule

// File: tb/sim_dma3d_addr_gen.sv
`timescale 1ns/1ps
module sim_dma3d_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_load = 1'b0, cfg_ab_mode = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [15:0] cfg_acnt = '0, cfg_bcnt = '0, cfg_bcnt_rld = '0, cfg_ccnt = '0;
  logic [15:0] cfg_src_bidx = '0, cfg_dst_bidx = '0, cfg_src_cidx = '0, cfg_dst_cidx = '0;
  logic        trig = 1'b0, req_ready = 1'b0;
  logic        req_valid, busy, done_mid, done_final, err;
  logic [31:0] req_src, req_dst, wb_src, wb_dst;
  logic [15:0] req_bytes, wb_bcnt, wb_ccnt;

  int n_checks = 0;
  int n_fail   = 0;

  // bench model of the context
  logic [31:0] m_src, m_dst;
  logic [15:0] m_a, m_b, m_rld, m_c, m_sb, m_db, m_sc, m_dc;
  logic        m_ab;

  always #2.5 clk = ~clk;

  dma3d_addr_gen u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_ab_mode(cfg_ab_mode),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_acnt(cfg_acnt), .cfg_bcnt(cfg_bcnt),
    .cfg_bcnt_rld(cfg_bcnt_rld), .cfg_ccnt(cfg_ccnt),
    .cfg_src_bidx(cfg_src_bidx), .cfg_dst_bidx(cfg_dst_bidx),
    .cfg_src_cidx(cfg_src_cidx), .cfg_dst_cidx(cfg_dst_cidx),
    .trig(trig), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_bytes(req_bytes), .busy(busy),
    .done_mid(done_mid), .done_final(done_final), .err(err),
    .wb_src(wb_src), .wb_dst(wb_dst), .wb_bcnt(wb_bcnt), .wb_ccnt(wb_ccnt)
  );

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic check_wb(input string req);
    chk(wb_src == m_src, req, "wb_src", wb_src, m_src);
    chk(wb_dst == m_dst, req, "wb_dst", wb_dst, m_dst);
    chk(wb_bcnt == m_b, req, "wb_bcnt", 32'(wb_bcnt), 32'(m_b));
    chk(wb_ccnt == m_c, req, "wb_ccnt", 32'(wb_ccnt), 32'(m_c));
  endtask

  task automatic load_cfg(input logic ab, input logic [31:0] s, input logic [31:0] d,
                          input logic [15:0] a, input logic [15:0] b, input logic [15:0] rl,
                          input logic [15:0] c, input logic [15:0] sb, input logic [15:0] db,
                          input logic [15:0] sc, input logic [15:0] dc);
    @(negedge clk);
    cfg_ab_mode = ab; cfg_src = s; cfg_dst = d; cfg_acnt = a; cfg_bcnt = b;
    cfg_bcnt_rld = rl; cfg_ccnt = c; cfg_src_bidx = sb; cfg_dst_bidx = db;
    cfg_src_cidx = sc; cfg_dst_cidx = dc; cfg_load = 1'b1;
    m_ab = ab; m_src = s; m_dst = d; m_a = a; m_b = b; m_rld = rl; m_c = c;
    m_sb = sb; m_db = db; m_sc = sc; m_dc = dc;
    @(negedge clk);
    cfg_load = 1'b0;
    #1;
    check_wb("R2");
  endtask

  // one trigger; poke injects a trigger and a load while the burst is running
  task automatic run_trig(input bit poke, output bit was_final);
    logic [31:0] es, ed, ps, pd;
    int n, k, guard;
    bit zero, have_prev, fin;
    was_final = 1'b0;
    zero = (m_a == 0) || (m_b == 0) || (m_c == 0);
    n = m_ab ? int'(m_b) : 1;
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    if (zero) begin
      #1;
      chk(err == 1'b1, "R9", "err", 32'(err), 32'd1);
      chk(!req_valid && !done_mid && !done_final, "R9", "quiet",
          {29'd0, req_valid, done_mid, done_final}, 32'd0);
      return;
    end
    es = m_src; ed = m_dst; k = 0; guard = 0; have_prev = 1'b0;
    while (k < n && guard < 5000) begin
      guard++;
      if (poke && guard <= 3) begin
        req_ready = 1'b0;
        trig      = (guard == 1);
        cfg_load  = (guard == 1);
        cfg_src   = (guard == 1) ? ~m_src : m_src;
      end else begin
        trig = 1'b0; cfg_load = 1'b0; cfg_src = m_src;
        req_ready = (($urandom % 4) != 0);
      end
      #1;
      if (have_prev) begin
        chk(req_valid && req_src == ps && req_dst == pd, "R11", "stall hold src", req_src, ps);
      end
      have_prev = 1'b0;
      if (req_valid && req_ready) begin
        chk(req_src == es, m_ab ? "R5" : "R3", "req_src", req_src, es);
        chk(req_dst == ed, "R6", "req_dst", req_dst, ed);
        chk(req_bytes == m_a, "R3", "req_bytes", 32'(req_bytes), 32'(m_a));
        es = es + sx(m_sb);
        ed = ed + sx(m_db);
        k++;
      end else if (req_valid) begin
        have_prev = 1'b1; ps = req_src; pd = req_dst;
      end
      @(negedge clk);
    end
    if (guard >= 5000) chk(1'b0, "R3", "request timeout", 32'(k), 32'(n));
    req_ready = 1'b0;
    // model update
    fin = 1'b0;
    if (!m_ab && m_b > 1) begin
      m_src = m_src + sx(m_sb); m_dst = m_dst + sx(m_db); m_b = m_b - 1;
    end else begin
      m_src = m_src + sx(m_sc); m_dst = m_dst + sx(m_dc);
      if (m_c == 1) begin
        m_b = 0; m_c = 0; fin = 1'b1;
      end else begin
        m_c = m_c - 1;
        if (!m_ab) m_b = m_rld;
      end
    end
    #1;
    chk(done_final == fin, "R8", "done_final", 32'(done_final), 32'(fin));
    chk(done_mid == !fin, "R7", "done_mid", 32'(done_mid), 32'(!fin));
    chk(!err && !req_valid, poke ? "R10" : "R7", "no extra req/err",
        {30'd0, err, req_valid}, 32'd0);
    check_wb(poke ? "R10" : (m_ab ? "R5" : "R4"));
    was_final = fin;
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    summary();
  end

  initial begin
    bit f;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!req_valid && !busy && !done_mid && !done_final && !err, "R1", "idle outputs",
        {27'd0, req_valid, busy, done_mid, done_final, err}, 32'd0);
    chk(wb_bcnt == 0 && wb_ccnt == 0, "R1", "counts", {wb_bcnt, wb_ccnt}, 32'd0);

    // twelve contiguous bytes, array at a time: 2x2x3, strides 2 and 2
    load_cfg(1'b0, 32'h100, 32'h800, 16'd2, 16'd2, 16'd2, 16'd3,
             16'd2, 16'd2, 16'd2, 16'd2);
    f = 1'b0;
    for (int i = 0; i < 6; i++) run_trig(1'b0, f);
    chk(f == 1'b1, "R8", "final after 6 triggers", 32'(f), 32'd1);
    chk(wb_src == 32'h10C, "R4", "contiguous end src", wb_src, 32'h10C);
    run_trig(1'b0, f);

    // same bytes, frame at a time: frame stride 4
    load_cfg(1'b1, 32'h100, 32'h800, 16'd2, 16'd2, 16'd2, 16'd3,
             16'd2, 16'd2, 16'd4, 16'd4);
    for (int i = 0; i < 3; i++) run_trig(1'b0, f);
    chk(f == 1'b1, "R8", "final after 3 frames", 32'(f), 32'd1);
    chk(wb_src == 32'h10C, "R5", "contiguous end src", wb_src, 32'h10C);

    // whole block in one trigger, with a mid-burst trigger and load
    load_cfg(1'b1, 32'h2000, 32'h3000, 16'd4, 16'd3, 16'd0, 16'd1,
             16'd4, 16'd8, 16'd0, 16'd0);
    run_trig(1'b1, f);
    chk(f == 1'b1, "R10", "single trigger block", 32'(f), 32'd1);

    // zero array size
    load_cfg(1'b0, 32'h10, 32'h20, 16'd0, 16'd2, 16'd2, 16'd2,
             16'd1, 16'd1, 16'd1, 16'd1);
    run_trig(1'b0, f);
    check_wb("R9");

    // wrap through zero both ways, separate negative strides
    load_cfg(1'b0, 32'hFFFF_FFFE, 32'h0000_0001, 16'd1, 16'd2, 16'd2, 16'd2,
             16'd4, 16'hFFFE, 16'h0010, 16'hFFF0);
    run_trig(1'b0, f);
    chk(wb_src == 32'h2, "R12", "src wrap", wb_src, 32'h2);
    chk(wb_dst == 32'hFFFF_FFFF, "R12", "dst wrap", wb_dst, 32'hFFFF_FFFF);
    while (!f) run_trig(1'b0, f);

    // random configurations, each run to its end and one trigger beyond
    for (int t = 0; t < 30; t++) begin
      load_cfg(1'($urandom % 2), $urandom, $urandom,
               16'(1 + $urandom % 8), 16'(1 + $urandom % 4), 16'(1 + $urandom % 4),
               16'(1 + $urandom % 3),
               16'($urandom % 128) - 16'd64, 16'($urandom % 128) - 16'd64,
               16'($urandom % 512) - 16'd256, 16'($urandom % 512) - 16'd256);
      f = 1'b0;
      while (!f) run_trig(($urandom % 5) == 0, f);
      run_trig(1'b0, f);
    end
    summary();
  end
endmodule